// File: doc/BRIEF.md
# Prime-Field Modular Multiplier with Cached Reduction Constant

This block computes `(A * B) mod P` for elliptic-curve arithmetic over prime fields of 192, 224, 256, 384 or 521 bits. A three-bit size code selects the field width `k`. Each operation runs in two phases. The first phase forms the full double-width integer product. The second phase reduces that product with a quotient estimate built from the constant `mu = floor(2^(2k) / P)`.

The constant comes from a bit-serial restoring divider. The divider runs only when the modulus or the size code differs from the previous accepted operation, or when no constant is held yet. A run of multiplications under a fixed modulus therefore pays for the division only once. One shared multiplier serves all three products. It splits each operand into high and low halves and uses three half-size products instead of four. The requester pulses `start_i` while `busy_o` is low and waits for the single-cycle `done_o`.

Top module: `mod_mul`

## Requirements
- R1: Size codes 0, 1, 2, 3 and 4 select k = 192, 224, 256, 384 and 521. Codes 5, 6 and 7 also select k = 521.
- R2: For P in [2^(k-1), 2^k) and A, B < P, the `result_o` presented with `done_o` equals (A*B) mod P.
- R3: Bits of `op_a_i`, `op_b_i` and `mod_i` at position k and above are ignored. They do not affect the result, and they do not count as a modulus change.
- R4: Bits of `result_o` at position k and above are zero, and `result_o` is below the latched modulus whenever `done_o` is high.
- R5: On the first operation after reset, or when the masked modulus or the size code differs from the previous accepted operation, `done_o` is high after the (2k+7)-th rising edge. The edge that accepts `start_i` counts as the first.
- R6: When the masked modulus and the size code equal those of the previous accepted operation, the division is skipped. `done_o` is then high after the 5th rising edge, counting the accepting edge.
- R7: `done_o` is high for exactly one cycle and `busy_o` is low in that cycle. `busy_o` is high from the accepting edge until then.
- R8: `start_i` is ignored while `busy_o` is high. Such a pulse does not change the result in progress, and it does not produce an extra `done_o`.
- R9: After reset, `busy_o` and `done_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when not busy |
| size_sel_i | input | 3 | Field size code |
| op_a_i | input | W | Multiplicand A |
| op_b_i | input | W | Multiplier B |
| mod_i | input | W | Modulus P |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | W | (A*B) mod P |

## Verification
The hardest case to reach is a modulus whose bits above the selected size change while its masked value stays the same. Here the cache must still hit, so the long division must not run again. The bench first runs a short-field operation to fill the cache. It then repeats the operation with random junk above bit k in the operands and the modulus, and checks both the 5-edge latency and the result. It also checks an operation that keeps the same modulus value under a different size code. The cache must miss there, and the bench checks the full division latency. Stray start pulses are driven in the middle of cached operations, and the bench confirms that exactly one correct result comes out.

// File: rtl/mod_mul_pkg.sv
package mod_mul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DIV, ST_MUL, ST_QEST, ST_QP, ST_FIX
  } mm_state_e;

  // field width for a size code; unused codes fall to the largest field
  function automatic logic [9:0] field_bits(input logic [2:0] sel);
    case (sel)
      3'd0:    return 10'd192;
      3'd1:    return 10'd224;
      3'd2:    return 10'd256;
      3'd3:    return 10'd384;
      default: return 10'd521;
    endcase
  endfunction
endpackage

// File: rtl/kara_mul.sv
module kara_mul #(
  parameter int N = 523
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] p_o
);
  localparam int H  = (N + 1) / 2;
  localparam int L  = N - H;
  localparam int PW = 2 * N;

  logic [2*H-1:0]   al_x, bl_x, z0;
  logic [2*L-1:0]   ah_x, bh_x, z2;
  logic [2*H+1:0]   as_x, bs_x, zs;
  logic [PW-1:0]    z0_w, z2_w, z1_w;

  always_comb begin
    al_x = {{H{1'b0}}, a_i[H-1:0]};
    bl_x = {{H{1'b0}}, b_i[H-1:0]};
    ah_x = {{L{1'b0}}, a_i[N-1:H]};
    bh_x = {{L{1'b0}}, b_i[N-1:H]};
    as_x = (2*H+2)'(a_i[H-1:0]) + (2*H+2)'(a_i[N-1:H]);
    bs_x = (2*H+2)'(b_i[H-1:0]) + (2*H+2)'(b_i[N-1:H]);
    z0   = al_x * bl_x;
    z2   = ah_x * bh_x;
    zs   = as_x * bs_x;
    z0_w = PW'(z0);
    z2_w = PW'(z2);
    z1_w = PW'(zs) - z2_w - z0_w;
    p_o  = (z2_w << (2*H)) + (z1_w << H) + z0_w;
  end
endmodule

// File: rtl/recip_div.sv
module recip_div #(
  parameter int W  = 521,
  parameter int KW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  div_i,
  input  logic [KW-1:0] k_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W+1:0]  quo_o
);
  localparam int CW = KW + 1;

  logic [W-1:0]  rem_q, div_q;
  logic [CW-1:0] cnt_q, first_q;
  logic [W+1:0]  quo_q;
  logic          run_q, done_q;
  logic [W:0]    rem_s;
  logic          ge;

  // dividend 2^(2k): only its leading bit is one
  always_comb begin
    rem_s = {rem_q, (cnt_q == first_q)};
    ge    = rem_s >= {1'b0, div_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; div_q <= '0; cnt_q <= '0; first_q <= '0;
      quo_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else if (start_i) begin
      rem_q   <= '0;
      quo_q   <= '0;
      div_q   <= div_i;
      cnt_q   <= {k_i, 1'b1};
      first_q <= {k_i, 1'b1};
      run_q   <= 1'b1;
      done_q  <= 1'b0;
    end else if (run_q) begin
      rem_q  <= ge ? W'(rem_s - {1'b0, div_q}) : W'(rem_s);
      quo_q  <= {quo_q[W:0], ge};
      cnt_q  <= cnt_q - 1'b1;
      run_q  <= cnt_q != CW'(1);
      done_q <= cnt_q == CW'(1);
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = run_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/mod_mul.sv
module mod_mul
  import mod_mul_pkg::*;
#(
  parameter int W = 521
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   size_sel_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic [W-1:0] mod_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  localparam int KW = $clog2(W + 1);
  localparam int MW = W + 2;
  localparam int PW = 2 * MW;

  mm_state_e     state_q;
  logic [KW-1:0] k_q, k_in;
  logic [2:0]    sel_q;
  logic [W-1:0]  a_q, b_q, p_q, res_q, in_mask, p_in;
  logic [MW-1:0] mu_q, q_q, r_q, ma, mb, pe, r1, r2;
  logic [PW-1:0] t_q, prod;
  logic          mu_vld_q, done_q, accept, miss;
  logic          div_busy, div_done;
  logic [MW-1:0] div_quo;

  always_comb begin
    k_in    = KW'(field_bits(size_sel_i));
    in_mask = ~({W{1'b1}} << k_in);
    p_in    = mod_i & in_mask;
    accept  = (state_q == ST_IDLE) && start_i;
    miss    = !mu_vld_q || (p_in != p_q) || (size_sel_i != sel_q);
  end

  recip_div #(.W(W), .KW(KW)) i_div (
    .clk_i, .rst_ni,
    .start_i(accept && miss),
    .div_i  (p_in),
    .k_i    (k_in),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  // one multiplier shared by all three product steps
  always_comb begin
    unique case (state_q)
      ST_QEST: begin ma = MW'(t_q >> (k_q - 1'b1)); mb = mu_q;       end
      ST_QP:   begin ma = q_q;                      mb = {2'b0, p_q}; end
      default: begin ma = {2'b0, a_q};              mb = {2'b0, b_q}; end
    endcase
  end

  kara_mul #(.N(MW)) i_mul (.a_i(ma), .b_i(mb), .p_o(prod));

  always_comb begin
    pe = {2'b0, p_q};
    r1 = (r_q >= pe) ? r_q - pe : r_q;
    r2 = (r1 >= pe) ? r1 - pe : r1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; k_q <= '0; sel_q <= '0;
      a_q <= '0; b_q <= '0; p_q <= '0; res_q <= '0;
      mu_q <= '0; q_q <= '0; r_q <= '0; t_q <= '0;
      mu_vld_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          a_q   <= op_a_i & in_mask;
          b_q   <= op_b_i & in_mask;
          p_q   <= p_in;
          k_q   <= k_in;
          sel_q <= size_sel_i;
          if (miss) begin
            mu_vld_q <= 1'b0;
            state_q  <= ST_DIV;
          end else begin
            state_q  <= ST_MUL;
          end
        end
        ST_DIV: if (div_done) begin
          mu_q     <= div_quo;
          mu_vld_q <= 1'b1;
          state_q  <= ST_MUL;
        end
        ST_MUL: begin
          t_q     <= prod;
          state_q <= ST_QEST;
        end
        ST_QEST: begin
          q_q     <= MW'(prod >> (k_q + 1'b1));
          state_q <= ST_QP;
        end
        ST_QP: begin
          r_q     <= MW'(t_q) - MW'(prod);
          state_q <= ST_FIX;
        end
        ST_FIX: begin
          res_q   <= W'(r2);
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = state_q != ST_IDLE;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

module mod_mul_chk #(
  parameter int W = 521
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o,
  input logic [W-1:0] p_q,
  input logic         mu_vld_q,
  input logic         div_busy
);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R8
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R4
  result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o < p_q));
  // R5
  div_stale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy |-> !mu_vld_q);
endmodule

bind mod_mul mod_mul_chk #(.W(W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .result_o(result_o), .p_q(p_q), .mu_vld_q(mu_vld_q),
  .div_busy(div_busy)
);

// File: tb/test_mod_mul.sv
module test_mod_mul;
  localparam int W = 521;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [2:0]   size_sel_i = '0;
  logic [W-1:0] op_a_i = '0, op_b_i = '0, mod_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] result_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk_i = ~clk_i;

  mod_mul #(.W(W)) i_mod_mul (.*);

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int kbits(input logic [2:0] s);
    case (s)
      3'd0: return 192;
      3'd1: return 224;
      3'd2: return 256;
      3'd3: return 384;
      default: return 521;
    endcase
  endfunction

  function automatic logic [W-1:0] kmask(input int k);
    logic [W-1:0] m = '0;
    for (int i = 0; i < k; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [W-1:0] rnd(input int k);
    logic [575:0] v = '0;
    for (int i = 0; i < 18; i++) v[i*32 +: 32] = $urandom;
    return v[W-1:0] & kmask(k);
  endfunction

  function automatic logic [W-1:0] ref_mm(input logic [W-1:0] a, b, p);
    logic [2*W-1:0] pr = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    logic [2*W-1:0] r  = pr % {{W{1'b0}}, p};
    return r[W-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one operation; a stray start pulse is issued mid-run when poke is set
  task automatic run_op(input logic [2:0] s, input logic [W-1:0] a, b, p,
                        input logic [W-1:0] exp_res, input int exp_lat,
                        input string tag, input bit poke);
    int lat;
    int dones;
    @(negedge clk_i);
    size_sel_i = s; op_a_i = a; op_b_i = b; mod_i = p; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    dones = 0;
    while (!done_o && lat < 3000) begin
      if (!busy_o) begin
        chk(1'b0, {tag, " R7 busy"}, W'(busy_o), W'(1));
      end
      if (poke && lat == 2) begin
        start_i = 1'b1; op_a_i = ~a; op_b_i = ~b; mod_i = ~p; size_sel_i = s + 3'd1;
      end
      if (poke && lat == 3) start_i = 1'b0;
      @(negedge clk_i);
      lat++;
    end
    chk(lat == exp_lat, {tag, " latency R5/R6"}, W'(lat), W'(exp_lat));
    chk(result_o == exp_res, {tag, " result R2"}, result_o, exp_res);
    chk((result_o & ~kmask(kbits(s))) == '0, {tag, " upper bits R4"}, result_o, exp_res);
    chk(!busy_o, {tag, " busy with done R7"}, W'(busy_o), W'(0));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      if (done_o) dones++;
    end
    chk(dones == 0, {tag, " single done R7/R8"}, W'(dones), W'(0));
  endtask

  initial begin
    logic [W-1:0] a, b, p, junk;
    int k;
    repeat (3) @(negedge clk_i);
    // R9
    chk(!busy_o && !done_o && result_o == '0, "reset R9", result_o, '0);
    rst_ni = 1'b1;

    for (int s = 0; s < 5; s++) begin
      k = kbits(3'(s));
      p = rnd(k);
      p[k-1] = 1'b1;
      a = rnd(k) % p; b = rnd(k) % p;
      run_op(3'(s), a, b, p, ref_mm(a, b, p), 2*k + 7, "new modulus R1 R5", 1'b0);
      for (int j = 0; j < 3; j++) begin
        a = rnd(k) % p; b = rnd(k) % p;
        run_op(3'(s), a, b, p, ref_mm(a, b, p), 5, "cached R6", j == 1);
      end
      run_op(3'(s), p - 1, p - 1, p, ref_mm(p - 1, p - 1, p), 5, "max operands R2", 1'b0);
      run_op(3'(s), '0, p - 1, p, '0, 5, "zero operand R2", 1'b0);
      p = kmask(k);
      a = p - 1; b = rnd(k) % p;
      run_op(3'(s), a, b, p, ref_mm(a, b, p), 2*k + 7, "all-ones modulus R5", 1'b0);
      p = '0; p[k-1] = 1'b1;
      a = p - 1; b = p - 2;
      run_op(3'(s), a, b, p, ref_mm(a, b, p), 2*k + 7, "smallest modulus R5", 1'b0);
    end

    // junk above the selected width: result intact, cache still hits (R3)
    k = 192;
    p = rnd(k); p[k-1] = 1'b1;
    a = rnd(k) % p; b = rnd(k) % p;
    run_op(3'd0, a, b, p, ref_mm(a, b, p), 2*k + 7, "prime cache R3", 1'b0);
    junk = ~kmask(k) & rnd(W);
    run_op(3'd0, a | junk, b | ~junk & ~kmask(k), p | junk, ref_mm(a, b, p), 5,
           "junk above k R3", 1'b0);

    // R1: code 7 behaves as the widest field, a new code forces a new constant
    p = rnd(W); p[W-1] = 1'b1;
    a = rnd(W) % p; b = rnd(W) % p;
    run_op(3'd7, a, b, p, ref_mm(a, b, p), 2*W + 7, "code 7 R1", 1'b0);
    run_op(3'd7, b, a, p, ref_mm(a, b, p), 5, "code 7 cached R1 R6", 1'b0);
    run_op(3'd4, a, b, p, ref_mm(a, b, p), 2*W + 7, "size code change R5", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule